// File: doc/BRIEF.md
# Flash Write-Buffer Load Sequencer

This block sits on the device side of a parallel NOR flash. It watches the host's bus write cycles and follows the write-buffer programming command. First come two unlock writes. Next comes the buffer-load command, written at an address inside the target sector. The following write carries the word count, again at that sector. The block then collects address/data pairs into a 16-word buffer. All pairs belong to a single write-buffer page.

After the counted number of loads, the block waits for the confirm command at the sector. A correct confirm raises a one-cycle start pulse toward the array writer. The array writer then reads three things from the block: the page base, the per-entry valid flags and the buffered words. These stay unchanged until the next load command.

Any broken rule raises a sticky abort flag and sends the sequencer back to idle. The broken rules are: a count above the buffer size, a load outside the page, a load outside the sector, or a wrong confirm. Writes that do not form a recognised sequence are dropped without any effect.

Top module: `wbuf_seq`

## Requirements
- R1: After reset, start_o and abort_o are 0, valid_o is all zero and page_o is zero.
- R2: A complete sequence starts a start_o pulse in the cycle after the write that confirms it. The confirm write carries command byte 29h (data_i[7:0]) at any address of the captured sector. The pulse is exactly one cycle long. The sequence before the confirm is: 555h/AAh, then 2AAh/55h (unlock addresses compared on addr_i[10:0]), then 25h at the sector, then the count at the sector, then count+1 loads.
- R3: A count byte greater than 0Fh sets abort_o and returns to idle. A count of 0Fh is accepted and takes 16 loads.
- R4: The first load fixes the page, which is addr_i[20:4] and is shown on page_o. A later load whose page differs sets abort_o.
- R5: The sector is addr_i[20:15], captured with the 25h command. If the count write or any load is outside that sector, abort_o is set.
- R6: The remaining-load counter drops by one on every load, repeats included. Once the count is used up, the next write must be the confirm, or abort_o is set.
- R7: A load writes data_i into entry addr_i[3:0] and sets that entry's valid bit. When an entry is loaded more than once, the last data is kept.
- R8: When the write after the last load is not 29h, or is not inside the sector, abort_o is set and no start pulse occurs.
- R9: Once set, abort_o stays high until the first unlock write (555h/AAh) arrives in idle.
- R10: Accepting the 25h command clears all valid bits in the following cycle.
- R11: The following writes produce neither start nor abort: a wrong second unlock, a command other than 25h after the unlock, and a 29h written in idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | One-cycle bus write strobe |
| addr_i | input | 21 | Word address of the write |
| data_i | input | 16 | Write data; commands in bits 7:0 |
| start_o | output | 1 | One-cycle pulse: buffer ready to program |
| abort_o | output | 1 | Sticky sequence-violation flag |
| page_o | output | 17 | Captured write-buffer page (address bits 20:4) |
| valid_o | output | 16 | Per-entry loaded flags |
| wdata_o | output | 256 | Buffered words, entry i at bits [16*i +: 16] |

## Verification
A wrong remaining-load count shows up at the confirm write. A count that is too short sets abort_o on a real load. A count that is too long swallows the confirm, so no start appears. Either way the error is visible one cycle after the write that exposes it. A sector or page register that holds a stale value turns a legal load into an abort in the next cycle. A lost buffer entry or valid bit shows directly on wdata_o and valid_o after the load.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNLK2, ST_CMD, ST_CNT, ST_LOAD, ST_CONF
  } seq_state_e;

  localparam logic [7:0]  CMD_UNLK1  = 8'hAA;
  localparam logic [7:0]  CMD_UNLK2  = 8'h55;
  localparam logic [7:0]  CMD_LOAD   = 8'h25;
  localparam logic [7:0]  CMD_CONF   = 8'h29;
  localparam logic [10:0] UNLK_ADDR1 = 11'h555;
  localparam logic [10:0] UNLK_ADDR2 = 11'h2AA;
endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [10:0] ulk_addr_i,
  input  logic [7:0]  cmd_i,
  input  logic        sect_hit_i,
  input  logic        page_hit_i,
  output seq_state_e  state_o,
  output logic        clr_o,
  output logic        load_o,
  output logic        sect_cap_o,
  output logic        page_cap_o,
  output logic        start_o,
  output logic        abort_o
);
  localparam logic [7:0] MAX_CNT = 8'(DEPTH - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] rem_q, rem_d;
  logic             first_q, first_d;
  logic             start_q, abort_q;
  logic             go, abt, clr_abt;
  logic             is_unlk1, is_unlk2;

  assign is_unlk1 = (ulk_addr_i == UNLK_ADDR1) && (cmd_i == CMD_UNLK1);
  assign is_unlk2 = (ulk_addr_i == UNLK_ADDR2) && (cmd_i == CMD_UNLK2);

  always_comb begin
    state_d    = state_q;
    rem_d      = rem_q;
    first_d    = first_q;
    clr_o      = 1'b0;
    load_o     = 1'b0;
    sect_cap_o = 1'b0;
    page_cap_o = 1'b0;
    go         = 1'b0;
    abt        = 1'b0;
    clr_abt    = 1'b0;
    if (we_i) begin
      unique case (state_q)
        ST_IDLE: if (is_unlk1) begin
          state_d = ST_UNLK2;
          clr_abt = 1'b1;
        end
        ST_UNLK2: state_d = is_unlk2 ? ST_CMD : ST_IDLE;
        ST_CMD: begin
          if (cmd_i == CMD_LOAD) begin
            state_d    = ST_CNT;
            sect_cap_o = 1'b1;
            clr_o      = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_CNT: begin
          if (!sect_hit_i || cmd_i > MAX_CNT) begin
            abt     = 1'b1;
            state_d = ST_IDLE;
          end else begin
            rem_d   = cmd_i[IDX_W-1:0];
            first_d = 1'b1;
            state_d = ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (!sect_hit_i || (!first_q && !page_hit_i)) begin
            abt     = 1'b1;
            state_d = ST_IDLE;
          end else begin
            load_o     = 1'b1;
            page_cap_o = first_q;
            first_d    = 1'b0;
            if (rem_q == '0) state_d = ST_CONF;
            else             rem_d   = rem_q - 1'b1;
          end
        end
        ST_CONF: begin
          if (sect_hit_i && cmd_i == CMD_CONF) go  = 1'b1;
          else                                 abt = 1'b1;
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      first_q <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      first_q <= first_d;
      start_q <= go;
      if (abt)          abort_q <= 1'b1;
      else if (clr_abt) abort_q <= 1'b0;
    end
  end

  assign state_o = state_q;
  assign start_o = start_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/wbuf_addr_chk.sv
module wbuf_addr_chk #(
  parameter int ADDR_W   = 21,
  parameter int SECT_LSB = 15,
  parameter int IDX_W    = 4,
  localparam int SECT_W  = ADDR_W - SECT_LSB,
  localparam int PAGE_W  = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sect_cap_i,
  input  logic              page_cap_i,
  output logic              sect_hit_o,
  output logic              page_hit_o,
  output logic [SECT_W-1:0] sect_o,
  output logic [PAGE_W-1:0] page_o
);
  logic [SECT_W-1:0] sect_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sect_q <= '0;
      page_q <= '0;
    end else begin
      if (sect_cap_i) sect_q <= addr_i[ADDR_W-1:SECT_LSB];
      if (page_cap_i) page_q <= addr_i[ADDR_W-1:IDX_W];
    end
  end

  assign sect_hit_o = addr_i[ADDR_W-1:SECT_LSB] == sect_q;
  assign page_hit_o = addr_i[ADDR_W-1:IDX_W] == page_q;
  assign sect_o     = sect_q;
  assign page_o     = page_q;
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    wr_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic [DEPTH-1:0]        valid_o,
  output logic [DEPTH*DATA_W-1:0] data_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (clr_i) begin
        vld_q <= 1'b0;
      end else if (wr_i && idx_i == IDX_W'(i)) begin
        vld_q <= 1'b1;
        dat_q <= data_i;
      end
    end

    assign valid_o[i]                   = vld_q;
    assign data_o[i*DATA_W +: DATA_W]   = dat_q;
  end
endmodule

// File: rtl/wbuf_seq.sv
module wbuf_seq
  import wbuf_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 16,
  parameter int SECT_LSB = 15,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int PAGE_W  = ADDR_W - IDX_W,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic                    start_o,
  output logic                    abort_o,
  output logic [PAGE_W-1:0]       page_o,
  output logic [DEPTH-1:0]        valid_o,
  output logic [DEPTH*DATA_W-1:0] wdata_o
);
  seq_state_e        state_w;
  logic              clr_w, load_w, sect_cap_w, page_cap_w;
  logic              sect_hit_w, page_hit_w;
  logic [SECT_W-1:0] sect_w;

  wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .ulk_addr_i (addr_i[10:0]),
    .cmd_i      (data_i[7:0]),
    .sect_hit_i (sect_hit_w),
    .page_hit_i (page_hit_w),
    .state_o    (state_w),
    .clr_o      (clr_w),
    .load_o     (load_w),
    .sect_cap_o (sect_cap_w),
    .page_cap_o (page_cap_w),
    .start_o    (start_o),
    .abort_o    (abort_o)
  );

  wbuf_addr_chk #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .IDX_W(IDX_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .sect_cap_i (sect_cap_w),
    .page_cap_i (page_cap_w),
    .sect_hit_o (sect_hit_w),
    .page_hit_o (page_hit_w),
    .sect_o     (sect_w),
    .page_o     (page_o)
  );

  wbuf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_w),
    .wr_i    (load_w),
    .idx_i   (addr_i[IDX_W-1:0]),
    .data_i  (data_i),
    .valid_o (valid_o),
    .data_o  (wdata_o)
  );
endmodule

// File: rtl/wbuf_seq_chk.sv
module wbuf_seq_chk
  import wbuf_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 16,
  parameter int SECT_LSB = 15,
  localparam int SECT_W  = ADDR_W - SECT_LSB
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic              start_o,
  input logic              abort_o,
  input logic [DEPTH-1:0]  valid_o,
  input seq_state_e        state_i,
  input logic [SECT_W-1:0] sect_i
);
  logic in_sect, unlk1_w;
  assign in_sect = addr_i[ADDR_W-1:SECT_LSB] == sect_i;
  assign unlk1_w = we_i && addr_i[10:0] == UNLK_ADDR1 && data_i[7:0] == CMD_UNLK1;

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R2
  AST_START_CONFIRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> ($past(we_i) && $past(data_i[7:0]) == CMD_CONF && $past(state_i) == ST_CONF)); // R8
  AST_COUNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CNT && we_i && data_i[7:0] > 8'(DEPTH - 1)) |=> abort_o); // R3
  AST_SECTOR_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_LOAD && we_i && !in_sect) |=> (abort_o && !start_o)); // R5
  AST_ABORT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !(state_i == ST_IDLE && unlk1_w)) |=> abort_o); // R9
  AST_VALID_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CMD && we_i && data_i[7:0] == CMD_LOAD) |=> valid_o == '0); // R10
  AST_IDLE_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |=> !start_o); // R11
endmodule

bind wbuf_seq wbuf_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .SECT_LSB(SECT_LSB)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .data_i  (data_i),
  .start_o (start_o),
  .abort_o (abort_o),
  .valid_o (valid_o),
  .state_i (state_w),
  .sect_i  (sect_w)
);

// File: tb/wbuf_seq_tb.sv
module wbuf_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [20:0]  addr = '0;
  logic [15:0]  data = '0;
  logic         start, abort;
  logic [16:0]  page;
  logic [15:0]  valid;
  logic [255:0] wdata;

  typedef struct {
    string        req;
    logic         start;
    logic         abort;
    logic [15:0]  valid;
    logic [16:0]  page;
    logic [255:0] data;
  } exp_t;

  exp_t         q[$];
  int           checks = 0, fails = 0;
  logic [15:0]  exp_valid = '0;
  logic [255:0] exp_data = '0;
  logic [16:0]  exp_page = '0;
  bit           first_ld = 0;

  localparam logic [20:0] SA = 21'h18000;
  localparam logic [20:0] P1 = 21'h18040;
  localparam logic [20:0] P2 = 21'h18230;
  localparam logic [20:0] OS = 21'h20040;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbuf_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .data_i(data),
    .start_o(start), .abort_o(abort), .page_o(page), .valid_o(valid), .wdata_o(wdata)
  );

  task automatic wr(input logic [20:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; data = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic push(input string r, input logic st, input logic ab);
    exp_t it;
    #1;
    it.req = r; it.start = st; it.abort = ab;
    it.valid = exp_valid; it.page = exp_page; it.data = exp_data;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic unlock();
    wr(21'h00555, 16'h00AA);
    wr(21'h002AA, 16'h0055);
  endtask

  task automatic load_cmd(input logic [20:0] sa);
    wr(sa, 16'h0025);
    exp_valid = '0;
    first_ld = 1;
  endtask

  task automatic begin_load(input logic [20:0] sa, input logic [7:0] cnt);
    unlock();
    load_cmd(sa);
    wr(sa, {8'h00, cnt});
  endtask

  task automatic ld(input logic [20:0] a, input logic [15:0] d);
    wr(a, d);
    exp_valid[a[3:0]] = 1'b1;
    exp_data[a[3:0]*16 +: 16] = d;
    if (first_ld) begin
      exp_page = a[20:4];
      first_ld = 0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    exp_t it;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      checks++;
      if (start !== it.start) begin
        fails++; $display("FAIL %s start act=%0b exp=%0b", it.req, start, it.start);
      end else if (abort !== it.abort) begin
        fails++; $display("FAIL %s abort act=%0b exp=%0b", it.req, abort, it.abort);
      end else if (valid !== it.valid) begin
        fails++; $display("FAIL %s valid act=%h exp=%h", it.req, valid, it.valid);
      end else if (page !== it.page) begin
        fails++; $display("FAIL %s page act=%h exp=%h", it.req, page, it.page);
      end else begin
        for (int i = 0; i < 16; i++)
          if (it.valid[i] && wdata[i*16 +: 16] !== it.data[i*16 +: 16]) begin
            fails++;
            $display("FAIL %s data[%0d] act=%h exp=%h", it.req, i,
                     wdata[i*16 +: 16], it.data[i*16 +: 16]);
          end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push("R1 reset", 0, 0);

    // R2/R6/R7: six loads, duplicate entries
    begin_load(SA, 8'h05);
    ld(P1 | 21'd2,  16'h1111);
    ld(P1 | 21'd7,  16'h2222);
    ld(P1 | 21'd2,  16'h3333);
    ld(P1 | 21'd0,  16'h4444);
    ld(P1 | 21'd15, 16'h5555);
    ld(P1 | 21'd7,  16'h6666);
    push("R6 no start before confirm", 0, 0);
    wr(SA, 16'h0029);
    push("R2 R7 confirm start", 1, 0);
    @(negedge clk);
    push("R2 single pulse", 0, 0);

    // R11: ignored writes
    wr(21'h00555, 16'h00AA);
    wr(21'h002AA, 16'h0056);
    push("R11 bad unlock", 0, 0);
    unlock();
    wr(SA, 16'h0080);
    push("R11 other cmd", 0, 0);
    wr(SA, 16'h0029);
    push("R11 idle confirm", 0, 0);

    // R10 then R3 boundary: full 16 loads
    unlock();
    load_cmd(SA);
    push("R10 valid cleared", 0, 0);
    wr(SA, 16'h000F);
    for (int i = 0; i < 16; i++) ld(P2 | 21'(i), 16'hA000 + 16'(i));
    wr(SA | 21'h123, 16'h0029);
    push("R3 R2 count 0F accepted", 1, 0);

    // R3: oversize count
    unlock();
    load_cmd(SA);
    wr(SA, 16'h0010);
    push("R3 count 10h aborts", 0, 1);

    // R9: sticky abort
    wr(SA, 16'h0029);
    wr(21'h002AA, 16'h0055);
    push("R9 abort held", 0, 1);
    wr(21'h00555, 16'h00AA);
    push("R9 abort cleared", 0, 0);

    // R4: page violation
    wr(21'h002AA, 16'h0055);
    load_cmd(SA);
    wr(SA, 16'h0001);
    ld(P1 | 21'd3, 16'h7777);
    wr(P2 | 21'd4, 16'h8888);
    push("R4 page abort", 0, 1);

    // R5: sector violations
    begin_load(SA, 8'h03);
    ld(P1 | 21'd1, 16'h9999);
    wr(OS | 21'd1, 16'hAAAA);
    push("R5 load sector abort", 0, 1);
    unlock();
    load_cmd(SA);
    wr(OS, 16'h0002);
    push("R5 count sector abort", 0, 1);

    // R6: repeated loads consume the count
    begin_load(SA, 8'h01);
    ld(P1 | 21'd9, 16'h0A0A);
    ld(P1 | 21'd9, 16'h0B0B);
    wr(P1 | 21'd10, 16'h0C0C);
    push("R6 R7 extra load aborts", 0, 1);

    // R8: bad confirm
    begin_load(SA, 8'h00);
    ld(P1 | 21'd5, 16'h1234);
    wr(SA, 16'h0028);
    push("R8 wrong confirm data", 0, 1);
    begin_load(SA, 8'h00);
    ld(P1 | 21'd6, 16'h4321);
    wr(OS, 16'h0029);
    push("R8 confirm wrong sector", 0, 1);
    @(negedge clk);
    push("R8 no late start", 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule